// File: doc/BRIEF.md
# Banked Interrupt Controller with Summary Shortcuts

The block gathers 72 level-sensitive interrupt lines into one active-high request to the processor. Eight lines form a basic group. The remaining 64 are split into two banks of 32 peripheral lines each. Global numbering runs 0–7 for the basic group, 8–39 for bank one and 40–71 for bank two. Each line has its own enable bit. Software sets enables through write-one set registers and clears them through a matching set of write-one clear registers. A line is pending when its raw input level is high and its enable is set.

Software first reads a summary word. This word shows the basic lines and one "anything pending" flag per bank. It also has shortcut bits that mirror eleven chosen bank lines directly, so a handler can often find the source with one read. Those mirrored lines are masked out of the per-bank pending words. A full scan of a bank therefore never reports the same source twice, and the per-bank flags follow only the lines that are not mirrored. Access is through a simple 32-bit port with separate read and write strobes and a registered read result.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit is 0, `irq_out` is 0 and all enable read-backs return 0.
- R2: A write to the set register of a group (basic 0x18, bank one 0x10, bank two 0x14) sets each enable whose data bit is 1 and leaves bits written as 0 unchanged.
- R3: A write to the clear register of a group (basic 0x24, bank one 0x1C, bank two 0x20) clears each enable whose data bit is 1 and leaves bits written as 0 unchanged.
- R4: Both the set register and the clear register of a group read back the current enables of that group, zero-extended.
- R5: The bank pending words read at 0x04 (bank one) and 0x08 (bank two) hold, at bit n, line n ANDed with its enable. Mirrored lines read as 0 there.
- R6: Summary word (0x00) bits 7:0 hold the enabled pending state of basic lines 0 to 7.
- R7: Summary bit 8 is 1 when any non-mirrored bank-one line is pending. Bit 9 is the same for bank two.
- R8: Summary bits 10 to 14 mirror pending bank-one lines 7, 9, 10, 18 and 19 in that order. Bits 15 to 20 mirror pending bank-two lines 21, 22, 23, 24, 25 and 30 in that order. Bits 31:21 read 0.
- R9: `irq_out` is the registered OR of every enabled pending line, mirrored ones included. It follows an input or enable change one clock edge later.
- R10: Writes to the pending words, to 0x0C and to unused offsets change no state. Offset 0x0C and unused offsets read 0.
- R11: `rdata` is loaded on the clock edge at which `rd_en` is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_basic | input | 8 | Basic interrupt lines, level high |
| src_bank1 | input | 32 | Bank-one interrupt lines, level high |
| src_bank2 | input | 32 | Bank-two interrupt lines, level high |
| addr | input | 6 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
An enable write takes effect at the clock edge that samples `wr_en`. The new state is visible to a read issued on a later cycle. A read result lands on `rdata` at the edge that samples `rd_en` and reflects the inputs and enables just before that edge. `irq_out` changes one edge after a source or enable change. Every stimulus is driven on the falling edge and sampled on the next falling edge. The `irq_out` latency check first confirms that the output is still low right after the source rises, then that it is high one edge later.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // Register offsets (bytes)
  localparam int OFF_SUM      = 'h00;
  localparam int OFF_PEND1    = 'h04;
  localparam int OFF_PEND2    = 'h08;
  localparam int OFF_FASTCTL  = 'h0C;
  localparam int OFF_SET1     = 'h10;
  localparam int OFF_SET2     = 'h14;
  localparam int OFF_SETB     = 'h18;
  localparam int OFF_CLR1     = 'h1C;
  localparam int OFF_CLR2     = 'h20;
  localparam int OFF_CLRB     = 'h24;

  // Bank lines mirrored into the summary word, in summary bit order
  localparam int SC1_N = 5;
  localparam int SC2_N = 6;
  localparam int SC1_LINE [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_LINE [SC2_N] = '{21, 22, 23, 24, 25, 30};
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else     en <= (en | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/irq_pend_view.sv
module irq_pend_view
  import irq_bank_pkg::*;
#(
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32,
  localparam int SUM_W  = BASIC_W + 2 + SC1_N + SC2_N
) (
  input  logic [BASIC_W-1:0] src_b,
  input  logic [BANK_W-1:0]  src_1,
  input  logic [BANK_W-1:0]  src_2,
  input  logic [BASIC_W-1:0] en_b,
  input  logic [BANK_W-1:0]  en_1,
  input  logic [BANK_W-1:0]  en_2,
  output logic [SUM_W-1:0]   summary,
  output logic [BANK_W-1:0]  view_1,
  output logic [BANK_W-1:0]  view_2,
  output logic               any_pend
);
  localparam int SC1_BASE = BASIC_W + 2;
  localparam int SC2_BASE = SC1_BASE + SC1_N;

  logic [BASIC_W-1:0] pb;
  logic [BANK_W-1:0]  p1, p2, mirror1, mirror2;
  logic [SC1_N-1:0]   sc1;
  logic [SC2_N-1:0]   sc2;

  assign pb = src_b & en_b;
  assign p1 = src_1 & en_1;
  assign p2 = src_2 & en_2;

  always_comb begin
    mirror1 = '0;
    mirror2 = '0;
    for (int k = 0; k < SC1_N; k++) mirror1[SC1_LINE[k]] = 1'b1;
    for (int k = 0; k < SC2_N; k++) mirror2[SC2_LINE[k]] = 1'b1;
  end

  generate
    for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
      assign sc1[k] = p1[SC1_LINE[k]];
    end
    for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
      assign sc2[k] = p2[SC2_LINE[k]];
    end
  endgenerate

  assign view_1 = p1 & ~mirror1;
  assign view_2 = p2 & ~mirror2;

  always_comb begin
    summary = '0;
    summary[BASIC_W-1:0]            = pb;
    summary[BASIC_W]                = |view_1;
    summary[BASIC_W+1]              = |view_2;
    summary[SC2_BASE-1:SC1_BASE]    = sc1;
    summary[SUM_W-1:SC2_BASE]       = sc2;
  end

  assign any_pend = (|pb) | (|p1) | (|p2);
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32,
  localparam int SUM_W  = BASIC_W + 2 + SC1_N + SC2_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SUM_W-1:0]   summary,
  input  logic [BANK_W-1:0]  view_1,
  input  logic [BANK_W-1:0]  view_2,
  input  logic [BASIC_W-1:0] en_b,
  input  logic [BANK_W-1:0]  en_1,
  input  logic [BANK_W-1:0]  en_2,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (addr)
      ADDR_W'(OFF_SUM):                    sel = DATA_W'(summary);
      ADDR_W'(OFF_PEND1):                  sel = DATA_W'(view_1);
      ADDR_W'(OFF_PEND2):                  sel = DATA_W'(view_2);
      ADDR_W'(OFF_SET1), ADDR_W'(OFF_CLR1): sel = DATA_W'(en_1);
      ADDR_W'(OFF_SET2), ADDR_W'(OFF_CLR2): sel = DATA_W'(en_2);
      ADDR_W'(OFF_SETB), ADDR_W'(OFF_CLRB): sel = DATA_W'(en_b);
      default:                             sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BASIC_W-1:0] src_basic,
  input  logic [BANK_W-1:0]  src_bank1,
  input  logic [BANK_W-1:0]  src_bank2,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_out
);
  localparam int SUM_W = BASIC_W + 2 + SC1_N + SC2_N;

  logic [BASIC_W-1:0] en_b, set_b, clr_b;
  logic [BANK_W-1:0]  en_1, set_1, clr_1;
  logic [BANK_W-1:0]  en_2, set_2, clr_2;
  logic [SUM_W-1:0]   summary;
  logic [BANK_W-1:0]  view_1, view_2;
  logic               any_pend;

  always_comb begin
    set_b = '0; clr_b = '0;
    set_1 = '0; clr_1 = '0;
    set_2 = '0; clr_2 = '0;
    if (wr_en) begin
      case (addr)
        ADDR_W'(OFF_SETB): set_b = wdata[BASIC_W-1:0];
        ADDR_W'(OFF_CLRB): clr_b = wdata[BASIC_W-1:0];
        ADDR_W'(OFF_SET1): set_1 = wdata[BANK_W-1:0];
        ADDR_W'(OFF_CLR1): clr_1 = wdata[BANK_W-1:0];
        ADDR_W'(OFF_SET2): set_2 = wdata[BANK_W-1:0];
        ADDR_W'(OFF_CLR2): clr_2 = wdata[BANK_W-1:0];
        default: ;
      endcase
    end
  end

  irq_enable_reg #(.W(BASIC_W)) u_en_b (
    .clk(clk), .rst(rst), .set_mask(set_b), .clr_mask(clr_b), .en(en_b));
  irq_enable_reg #(.W(BANK_W)) u_en_1 (
    .clk(clk), .rst(rst), .set_mask(set_1), .clr_mask(clr_1), .en(en_1));
  irq_enable_reg #(.W(BANK_W)) u_en_2 (
    .clk(clk), .rst(rst), .set_mask(set_2), .clr_mask(clr_2), .en(en_2));

  irq_pend_view #(.BASIC_W(BASIC_W), .BANK_W(BANK_W)) u_view (
    .src_b(src_basic), .src_1(src_bank1), .src_2(src_bank2),
    .en_b(en_b), .en_1(en_1), .en_2(en_2),
    .summary(summary), .view_1(view_1), .view_2(view_2),
    .any_pend(any_pend));

  irq_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASIC_W(BASIC_W),
                 .BANK_W(BANK_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .summary(summary), .view_1(view_1), .view_2(view_2),
    .en_b(en_b), .en_1(en_1), .en_2(en_2), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= any_pend;
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [BASIC_W-1:0] src_basic,
  input logic [BANK_W-1:0]  src_bank1,
  input logic [BANK_W-1:0]  src_bank2,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wdata,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_out,
  input logic [BASIC_W-1:0] en_b,
  input logic [BANK_W-1:0]  en_1,
  input logic [BANK_W-1:0]  en_2
);
  localparam int SUM_W = BASIC_W + 2 + SC1_N + SC2_N;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_out && en_b == '0 && en_1 == '0 && en_2 == '0));

  // R2
  set_basic_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_SETB)) |=>
      ((en_b & $past(wdata[BASIC_W-1:0])) == $past(wdata[BASIC_W-1:0])));

  // R2
  set_bank1_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_SET1)) |=>
      ((en_1 & $past(wdata[BANK_W-1:0])) == $past(wdata[BANK_W-1:0])));

  // R3
  clr_bank2_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CLR2)) |=>
      ((en_2 & $past(wdata[BANK_W-1:0])) == '0));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(en_b) && $stable(en_1) && $stable(en_2)));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past((|(src_basic & en_b)) |
                                      (|(src_bank1 & en_1)) |
                                      (|(src_bank2 & en_2)))));

  // R8
  sum_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFF_SUM)) |=> (rdata[DATA_W-1:SUM_W] == '0));

  // R4
  readback_bank1_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFF_CLR1)) |=> (rdata == DATA_W'($past(en_1))));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASIC_W(BASIC_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .src_basic(src_basic), .src_bank1(src_bank1),
  .src_bank2(src_bank2), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out),
  .en_b(en_b), .en_1(en_1), .en_2(en_2));

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_basic = '0;
  logic [31:0] src_bank1 = '0;
  logic [31:0] src_bank2 = '0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk(clk), .rst(rst), .src_basic(src_basic), .src_bank1(src_bank1),
    .src_bank2(src_bank2), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out));

  typedef struct packed {
    logic [7:0]  eb;
    logic [31:0] e1, e2;
    logic [7:0]  sb;
    logic [31:0] s1, s2;
    logic [31:0] sum, p1, p2;
    logic        irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h01, 32'h0, 32'h0,
      32'h00000001, 32'h0, 32'h0, 1'b1},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'h00000080, 32'h0,
      32'h00000400, 32'h0, 32'h0, 1'b1},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'h00000001, 32'h0,
      32'h00000100, 32'h00000001, 32'h0, 1'b1},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'h0, 32'h40000000,
      32'h00100000, 32'h0, 32'h0, 1'b1},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'h0, 32'h00200001,
      32'h00008200, 32'h0, 32'h00000001, 1'b1},
    '{8'hFF, 32'h0, 32'hFFFFFFFF, 8'h80, 32'hFFFFFFFF, 32'h0,
      32'h00000080, 32'h0, 32'h0, 1'b1},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'h0, 32'h0,
      32'h0, 32'h0, 32'h0, 1'b0},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'h000C0000, 32'h02000000,
      32'h00086000, 32'h0, 32'h0, 1'b1},
    '{8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
      32'h001FFFFF, 32'hFFF3F97F, 32'hBC1FFFFF, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(6'h18, d); check("R1 basic enables", d, 32'h0);
    rd(6'h10, d); check("R1 bank1 enables", d, 32'h0);
    rd(6'h14, d); check("R1 bank2 enables", d, 32'h0);

    // Table walk: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr(6'h24, 32'hFFFFFFFF);
      wr(6'h1C, 32'hFFFFFFFF);
      wr(6'h20, 32'hFFFFFFFF);
      wr(6'h18, {24'b0, VEC[i].eb});
      wr(6'h10, VEC[i].e1);
      wr(6'h14, VEC[i].e2);
      src_basic = VEC[i].sb;
      src_bank1 = VEC[i].s1;
      src_bank2 = VEC[i].s2;
      rd(6'h00, d); check($sformatf("R6 R7 R8 summary vec %0d", i), d, VEC[i].sum);
      rd(6'h04, d); check($sformatf("R5 bank1 pending vec %0d", i), d, VEC[i].p1);
      rd(6'h08, d); check($sformatf("R5 bank2 pending vec %0d", i), d, VEC[i].p2);
      check($sformatf("R9 irq_out vec %0d", i), {31'b0, irq_out}, {31'b0, VEC[i].irq});
    end

    src_basic = '0; src_bank1 = '0; src_bank2 = '0;
    wr(6'h24, 32'hFFFFFFFF);
    wr(6'h1C, 32'hFFFFFFFF);
    wr(6'h20, 32'hFFFFFFFF);

    // R2: zero bits leave enables alone
    wr(6'h18, 32'h3);
    wr(6'h18, 32'h0);
    wr(6'h18, 32'h4);
    rd(6'h18, d); check("R2 basic set accumulates", d, 32'h7);
    wr(6'h10, 32'h80000000);
    rd(6'h10, d); check("R2 bank1 set top bit", d, 32'h80000000);

    // R3 and R4
    wr(6'h24, 32'h1);
    rd(6'h18, d); check("R3 basic clear one bit", d, 32'h6);
    rd(6'h24, d); check("R4 clear register read-back", d, 32'h6);
    wr(6'h1C, 32'h0);
    rd(6'h1C, d); check("R3 R4 bank1 zero clear no effect", d, 32'h80000000);

    // R10: writes to read-only and unused offsets
    wr(6'h00, 32'hFFFFFFFF);
    wr(6'h04, 32'hFFFFFFFF);
    wr(6'h0C, 32'hFFFFFFFF);
    wr(6'h28, 32'hFFFFFFFF);
    rd(6'h18, d); check("R10 basic enables unchanged", d, 32'h6);
    rd(6'h14, d); check("R10 bank2 enables unchanged", d, 32'h0);
    rd(6'h00, d); check("R10 summary unchanged", d, 32'h0);
    rd(6'h0C, d); check("R10 offset 0x0C reads zero", d, 32'h0);
    rd(6'h28, d); check("R10 unused offset reads zero", d, 32'h0);

    // R9: one-edge latency on irq_out (basic bit 1 enabled)
    @(negedge clk);
    src_basic = 8'h02;
    #1;
    check("R9 irq_out before edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R9 irq_out after edge", {31'b0, irq_out}, 32'h1);
    src_basic = 8'h01;
    @(negedge clk);
    check("R9 disabled line gives no irq", {31'b0, irq_out}, 32'h0);

    // R11: rdata holds without rd_en
    src_basic = 8'h04;
    rd(6'h00, held);
    check("R11 read result", held, 32'h4);
    src_basic = 8'h00;
    repeat (3) @(negedge clk);
    check("R11 rdata held", rdata, 32'h4);

    finish_run();
  end
endmodule